// File: doc/BRIEF.md
# Status-Flag Arithmetic and Logic Unit

This block is the execute stage of a small 16-bit microcontroller datapath. Each cycle with `op_valid` high, it takes an operation code, a source and a destination operand, a byte/word select and a flag saying whether the destination is a register. It then registers the result together with a write-enable for the destination. In the same cycle it updates the negative, zero, carry and overflow flags inside a status word.

The operation set covers the following:
- binary addition, with and without carry-in;
- subtraction formed by adding the inverted source;
- packed-decimal addition;
- bitwise operations;
- flag-only compare and bit-test;
- single-operand rotate, byte swap and sign extension.

The status word also holds an interrupt-enable bit and four power/clock control bits. The unit never alters them, and surrounding sequencing logic can overwrite the whole word through a load port.

The operand fetch and instruction decoding stages sit outside this block. They present already-fetched operand values and a 4-bit operation code. The operation code values are listed in the requirements.

Top module: `flag_alu`

## Requirements
- R1: While reset is active, and after its synchronous release, `result` is 0x0000, `result_we` is 0 and `status` is 0x0000.
- R2: The arithmetic results are computed from destination D, source S and stored carry C as follows:
  - code 1 gives D+S;
  - code 2 gives D+S+C;
  - code 4 gives D+~S+1;
  - code 3 gives D+~S+C.
  
  Every result is truncated to the operand width. The result appears one clock after the operation is presented.
- R3: Codes 1–5 set the flags in these status bit positions:
  - N (bit 2) takes the result MSB;
  - Z (bit 1) is set when the result is zero;
  - C (bit 0) takes the carry out of the operand width;
  - V (bit 8) is set on two's-complement signed overflow.
- R4: Code 6 adds D, S and C as packed BCD digits, giving two digits in byte mode and four in word mode. C takes the decimal carry out of the top digit, V is cleared, and N and Z follow the result.
- R5: Code 5 (compare) sets the flags as subtraction with code 4 does. Code 7 (bit test) sets the flags as code 11 does. Both drive `result_we` low in the following cycle, and every other valid operation drives it high.
- R6: The bitwise codes are handled as follows:
  - Code 11 (AND) and code 10 (XOR) set N and Z from the result, set C to the inverse of Z, and clear V.
  - Code 8 (~S AND D) and code 9 (S OR D) leave all flags unchanged.
- R7: Code 0 passes S through and code 14 exchanges the two bytes of D. Neither changes any flag.
- R8: With `byte_mode`=1, an operation uses bits 7:0 of its operands, and N, C and V are taken at bit 7 and the 8-bit carry. The upper byte of the result is then zero if `dst_is_reg`=1, or D[15:8] otherwise (for example 0x5F+0x02 gives 0x0061 to a register).
- R9: The two rotate codes operate on D and send its LSB into C:
  - code 13 shifts right and keeps the sign bit;
  - code 12 shifts right with the old C entering the MSB.
  
  Both set N and Z from the result and clear V.
- R10: Code 15 copies bit 7 of D into bits 15:8. Its flags follow the rule that code 11 uses. Codes 14 and 15 always work on the full word, whatever `byte_mode` is.
- R11: Status bits 3–7 and 9–15 are changed only by `sr_load`, never by an operation.
- R12: With `op_valid`=0 and `sr_load`=0, `result` and `status` hold and `result_we` is 0. When `sr_load` is 1, `status` takes `sr_wdata` on the next clock, and this takes precedence over any flag update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation selector (values in R2–R10) |
| byte_mode | input | 1 | 1 = byte operation, 0 = word |
| dst_is_reg | input | 1 | Destination is a register (byte result upper byte cleared) |
| src_val | input | 16 | Source operand S |
| dst_val | input | 16 | Destination operand D |
| sr_load | input | 1 | Overwrite the status word |
| sr_wdata | input | 16 | Value loaded into the status word |
| result | output | 16 | Registered result |
| result_we | output | 1 | Registered destination write-enable |
| status | output | 16 | Status word: C bit 0, Z bit 1, N bit 2, V bit 8 |

## Verification
Word additions are driven at the signed boundary (0x7FFF+1) and the unsigned boundary (0xFFFF+1), which separates V from C and shows Z on wrap. Subtractions with a borrow separate the +1 form from the +C form. Decimal sums that ripple through several 9 digits, and one that wraps past 9999, distinguish decimal correction from binary carry. Byte-mode operations are run both to a register and to memory with a non-zero upper byte, so upper-byte clearing can be told apart from preservation. The status word is preloaded with all control bits set, or with flags set before flag-neutral operations, which exposes any write to bits an operation must not touch.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    OP_MOV  = 4'd0,
    OP_ADD  = 4'd1,
    OP_ADDC = 4'd2,
    OP_SUBC = 4'd3,
    OP_SUB  = 4'd4,
    OP_CMP  = 4'd5,
    OP_DADD = 4'd6,
    OP_BIT  = 4'd7,
    OP_BIC  = 4'd8,
    OP_BIS  = 4'd9,
    OP_XOR  = 4'd10,
    OP_AND  = 4'd11,
    OP_RRC  = 4'd12,
    OP_RRA  = 4'd13,
    OP_SWPB = 4'd14,
    OP_SXT  = 4'd15
  } alu_op_e;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 8;

endpackage

// File: rtl/flag_alu_adder.sv
// Binary adder with optional source inversion; reports carry and signed
// overflow at both the full width and the half (byte) width.
module flag_alu_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         invert_b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         co_full,
  output logic         co_half,
  output logic         ovf_full,
  output logic         ovf_half
);
  localparam int H  = W / 2;
  localparam int WP = W + 1;

  logic [W-1:0] bx;

  always_comb begin
    bx = invert_b ? ~b : b;
    {co_full, sum} = {1'b0, a} + {1'b0, bx} + WP'(cin);
    // carry into bit H recovered from the sum bit and the two addend bits
    co_half  = sum[H] ^ a[H] ^ bx[H];
    ovf_full = (a[W-1] == bx[W-1]) && (sum[W-1] != a[W-1]);
    ovf_half = (a[H-1] == bx[H-1]) && (sum[H-1] != a[H-1]);
  end
endmodule

// File: rtl/flag_alu_bcd.sv
// Packed-decimal adder: one corrected digit stage per nibble, carry rippled.
module flag_alu_bcd #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         co_full,
  output logic         co_half
);
  localparam int ND = W / 4;

  logic [ND:0] dc;

  assign dc[0] = cin;

  for (genvar d = 0; d < ND; d++) begin : g_digit
    logic [4:0] raw;
    logic       fix;
    assign raw = {1'b0, a[4*d +: 4]} + {1'b0, b[4*d +: 4]} + 5'(dc[d]);
    assign fix = raw > 5'd9;
    assign sum[4*d +: 4] = fix ? (raw[3:0] + 4'd6) : raw[3:0];
    assign dc[d+1] = fix;
  end

  assign co_full = dc[ND];
  assign co_half = dc[ND/2];
endmodule

// File: rtl/flag_alu_logic.sv
// Bitwise, move, rotate and byte-rearranging operations.
module flag_alu_logic
  import flag_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic         byte_mode,
  input  logic         cin,
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  output logic [W-1:0] res
);
  localparam int H = W / 2;

  always_comb begin
    res = '0;
    unique case (op)
      OP_MOV:         res = src;
      OP_AND, OP_BIT: res = src & dst;
      OP_BIC:         res = ~src & dst;
      OP_BIS:         res = src | dst;
      OP_XOR:         res = src ^ dst;
      OP_SWPB:        res = {dst[H-1:0], dst[W-1:H]};
      OP_SXT:         res = {{H{dst[H-1]}}, dst[H-1:0]};
      OP_RRA: begin
        if (byte_mode) res = {{H{1'b0}}, dst[H-1], dst[H-1:1]};
        else           res = {dst[W-1], dst[W-1:1]};
      end
      OP_RRC: begin
        if (byte_mode) res = {{H{1'b0}}, cin, dst[H-1:1]};
        else           res = {cin, dst[W-1:1]};
      end
      default:        res = '0;
    endcase
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [3:0]   op_code,
  input  logic         byte_mode,
  input  logic         dst_is_reg,
  input  logic [W-1:0] src_val,
  input  logic [W-1:0] dst_val,
  input  logic         sr_load,
  input  logic [W-1:0] sr_wdata,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic [W-1:0] status
);
  localparam int H = W / 2;

  // ---------------- reset release synchronizer ----------------
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // ---------------- decode ----------------
  alu_op_e op;
  logic    c_old;
  logic    is_arith, is_sub, add_cin, word_only, eff_byte;

  always_comb begin
    op        = alu_op_e'(op_code);
    c_old     = status[FLAG_C];
    is_arith  = op inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP};
    is_sub    = op inside {OP_SUB, OP_SUBC, OP_CMP};
    word_only = op inside {OP_SWPB, OP_SXT};
    eff_byte  = byte_mode && !word_only;
    unique case (op)
      OP_ADD:              add_cin = 1'b0;
      OP_ADDC, OP_SUBC:    add_cin = c_old;
      default:             add_cin = 1'b1;
    endcase
  end

  // ---------------- datapath units ----------------
  logic [W-1:0] add_sum, bcd_sum, lg_res;
  logic         add_co_f, add_co_h, add_v_f, add_v_h, bcd_co_f, bcd_co_h;

  flag_alu_adder #(.W(W)) u_adder (
    .a(dst_val), .b(src_val), .invert_b(is_sub), .cin(add_cin),
    .sum(add_sum), .co_full(add_co_f), .co_half(add_co_h),
    .ovf_full(add_v_f), .ovf_half(add_v_h)
  );

  flag_alu_bcd #(.W(W)) u_bcd (
    .a(dst_val), .b(src_val), .cin(c_old),
    .sum(bcd_sum), .co_full(bcd_co_f), .co_half(bcd_co_h)
  );

  flag_alu_logic #(.W(W)) u_logic (
    .op(op), .byte_mode(eff_byte), .cin(c_old),
    .src(src_val), .dst(dst_val), .res(lg_res)
  );

  // ---------------- result shaping and flags ----------------
  logic [W-1:0] raw_res, shaped;
  logic         res_msb, res_zero;
  logic         fl_upd, c_new, v_new;

  always_comb begin
    if (is_arith)          raw_res = add_sum;
    else if (op == OP_DADD) raw_res = bcd_sum;
    else                   raw_res = lg_res;

    if (eff_byte) begin
      res_msb  = raw_res[H-1];
      res_zero = (raw_res[H-1:0] == '0);
      shaped   = {(dst_is_reg ? {H{1'b0}} : dst_val[W-1:H]), raw_res[H-1:0]};
    end else begin
      res_msb  = raw_res[W-1];
      res_zero = (raw_res == '0);
      shaped   = raw_res;
    end

    fl_upd = 1'b1;
    c_new  = c_old;
    v_new  = 1'b0;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        c_new = eff_byte ? add_co_h : add_co_f;
        v_new = eff_byte ? add_v_h  : add_v_f;
      end
      OP_DADD:                        c_new = eff_byte ? bcd_co_h : bcd_co_f;
      OP_AND, OP_BIT, OP_XOR, OP_SXT: c_new = !res_zero;
      OP_RRA, OP_RRC:                 c_new = dst_val[0];
      default:                        fl_upd = 1'b0;
    endcase
  end

  // ---------------- next state ----------------
  logic [W-1:0] nx_result, nx_status;
  logic         nx_we, res_en, sr_en;

  always_comb begin
    nx_result = shaped;
    nx_we     = op_valid && !(op inside {OP_CMP, OP_BIT});
    res_en    = op_valid;
    sr_en     = sr_load || (op_valid && fl_upd);
    nx_status = status;
    if (op_valid && fl_upd) begin
      nx_status[FLAG_C] = c_new;
      nx_status[FLAG_Z] = res_zero;
      nx_status[FLAG_N] = res_msb;
      nx_status[FLAG_V] = v_new;
    end
    if (sr_load) nx_status = sr_wdata;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      result    <= '0;
      result_we <= 1'b0;
      status    <= '0;
    end else begin
      if (res_en) result <= nx_result;
      result_we <= nx_we;
      if (sr_en)  status <= nx_status;
    end
  end

  // ---------------- assertions ----------------
  // R5: compare and bit test never request a write
  a_r5_no_writeback: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && (op == OP_CMP || op == OP_BIT) |=> !result_we);

  // R11: control bits move only through a load
  a_r11_ctrl_bits_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sr_load |=> (status[7:3] == $past(status[7:3])) &&
                 (status[W-1:9] == $past(status[W-1:9])));

  // R6 / R7: flag-neutral operations leave the whole status word alone
  a_r7_flags_frozen: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && !sr_load && (op inside {OP_MOV, OP_SWPB, OP_BIC, OP_BIS})
    |=> $stable(status));

  // R8: byte result to a register has a clear upper byte
  a_r8_reg_upper_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && byte_mode && dst_is_reg && !(op inside {OP_SWPB, OP_SXT})
    |=> result[W-1:H] == '0);

  // R3: N and Z agree with the registered word result of arithmetic
  a_r3_nz_match: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && !sr_load && !byte_mode && (op inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP})
    |=> (status[FLAG_Z] == (result == '0)) && (status[FLAG_N] == result[W-1]));

  // R12: idle cycles hold everything
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !op_valid && !sr_load |=> $stable(status) && $stable(result) && !result_we);

endmodule

// File: tb/flag_alu_test.sv
module flag_alu_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, byte_mode, dst_is_reg, sr_load;
  logic [3:0]  op_code;
  logic [15:0] src_val, dst_val, sr_wdata;
  logic [15:0] result, status;
  logic        result_we;

  int checks = 0;
  int errors = 0;
  int m_sr = 0;
  int m_res = 0;

  always #4 clk = ~clk;

  flag_alu uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .byte_mode(byte_mode), .dst_is_reg(dst_is_reg), .src_val(src_val),
    .dst_val(dst_val), .sr_load(sr_load), .sr_wdata(sr_wdata),
    .result(result), .result_we(result_we), .status(status)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int sx(input int x, input int w);
    return (x >= (1 << (w-1))) ? x - (1 << w) : x;
  endfunction

  function automatic int bcd2int(input int x, input int nd);
    int v = 0, m = 1;
    for (int i = 0; i < nd; i++) begin
      v += ((x >> (4*i)) & 15) * m;
      m *= 10;
    end
    return v;
  endfunction

  function automatic int int2bcd(input int v, input int nd);
    int x = 0;
    for (int i = 0; i < nd; i++) begin
      x |= (v % 10) << (4*i);
      v /= 10;
    end
    return x;
  endfunction

  // one clock: drive at falling edge, predict, compare at next falling edge
  task automatic step(input bit v, input int op, input bit b, input bit isreg,
                      input int src, input int dst, input bit ld, input int ldval,
                      input string tag);
    bit wordonly;
    int w, mask, s, d, bop, ci, cin, r, cf, vf, mode, n, z, sv, dv, lim, exp_we;
    op_valid = v; op_code = 4'(op); byte_mode = b; dst_is_reg = isreg;
    src_val = 16'(src); dst_val = 16'(dst); sr_load = ld; sr_wdata = 16'(ldval);
    exp_we = 0;
    if (v) begin
      wordonly = (op == 14 || op == 15);
      w = (b && !wordonly) ? 8 : 16;
      mask = (1 << w) - 1;
      s = src & mask; d = dst & mask; cin = m_sr & 1;
      r = 0; cf = 0; vf = 0; mode = 0;
      case (op)
        0: r = s;
        1, 2, 3, 4, 5: begin
          bop = (op >= 3) ? (~s) & mask : s;
          ci  = (op == 1) ? 0 : ((op == 2 || op == 3) ? cin : 1);
          r   = d + bop + ci;
          cf  = (r >> w) & 1;
          r  &= mask;
          sv  = sx(d, w) + sx(bop, w) + ci;
          vf  = (sv > (1 << (w-1)) - 1 || sv < -(1 << (w-1))) ? 1 : 0;
          mode = 1;
        end
        6: begin
          lim = 1;
          for (int i = 0; i < w/4; i++) lim *= 10;
          dv = bcd2int(d, w/4) + bcd2int(s, w/4) + cin;
          cf = (dv >= lim) ? 1 : 0;
          if (cf != 0) dv -= lim;
          r = int2bcd(dv, w/4);
          mode = 1;
        end
        7, 11: begin r = s & d; mode = 2; end
        8:  r = (~s) & d & mask;
        9:  r = s | d;
        10: begin r = s ^ d; mode = 2; end
        12: begin cf = d & 1; r = (d >> 1) | (cin << (w-1)); mode = 1; end
        13: begin cf = d & 1; r = (d >> 1) | (d & (1 << (w-1))); mode = 1; end
        14: r = ((dst & 255) << 8) | ((dst >> 8) & 255);
        15: begin r = ((dst & 128) != 0) ? ((dst & 255) | 'hFF00) : (dst & 255); mode = 2; end
        default: r = 0;
      endcase
      n = (r >> (w-1)) & 1;
      z = (r == 0) ? 1 : 0;
      if (mode == 2) begin cf = 1 - z; vf = 0; end
      if (mode != 0) m_sr = (m_sr & ~'h0107) | (vf << 8) | (n << 2) | (z << 1) | cf;
      if (w == 8) r = isreg ? r : ((dst & 'hFF00) | r);
      m_res = r & 'hFFFF;
      exp_we = (op == 5 || op == 7) ? 0 : 1;
    end
    if (ld) m_sr = ldval & 'hFFFF;
    @(negedge clk);
    check(int'(result) == m_res, tag, "result", int'(result), m_res);
    check(int'(result_we) == exp_we, tag, "write-enable", int'(result_we), exp_we);
    check(int'(status) == m_sr, tag, "status", int'(status), m_sr);
  endtask

  task automatic do_op(input int op, input bit b, input bit isreg,
                       input int src, input int dst, input string tag);
    step(1'b1, op, b, isreg, src, dst, 1'b0, 0, tag);
  endtask

  task automatic ld(input int val);
    step(1'b0, 0, 1'b0, 1'b1, 0, 0, 1'b1, val, "R12 status load");
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = 4'd0; byte_mode = 1'b0;
    dst_is_reg = 1'b1; sr_load = 1'b0; src_val = '0; dst_val = '0; sr_wdata = '0;
    repeat (3) @(negedge clk);
    check(result == 16'h0 && result_we == 1'b0 && status == 16'h0, "R1", "reset state",
          int'(result) | int'(status), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(result == 16'h0, "R1", "result after release", int'(result), 0);
    check(result_we == 1'b0, "R1", "we after release", int'(result_we), 0);
    check(status == 16'h0, "R1", "status after release", int'(status), 0);

    // R2 basic arithmetic forms
    do_op(1, 0, 1, 'h1234, 'h0FF0, "R2 add");
    ld('h0001);
    do_op(2, 0, 1, 'h0010, 'h0020, "R2 add with carry");
    do_op(4, 0, 1, 7, 5, "R2 sub borrow");
    ld('h0001);
    do_op(3, 0, 1, 3, 10, "R2 sub with carry");
    // R3 flag boundaries
    do_op(1, 0, 1, 1, 'h7FFF, "R3 signed overflow");
    do_op(1, 0, 1, 1, 'hFFFF, "R3 carry and zero");
    do_op(4, 0, 1, 1, 'h8000, "R3 sub overflow");
    // R4 decimal
    ld('h0000);
    do_op(6, 0, 1, 1, 'h0999, "R4 decimal ripple");
    do_op(6, 0, 1, 1, 'h9999, "R4 decimal wrap");
    ld('h0001);
    do_op(6, 1, 0, 'h01, 'h1298, "R4 decimal byte with carry");
    // R5 flag-only operations
    do_op(5, 0, 1, 'h0042, 'h0042, "R5 compare equal");
    do_op(5, 0, 1, 'h0050, 'h0010, "R5 compare less");
    do_op(7, 0, 1, 'h00F0, 'h0F0F, "R5 bit test zero");
    // R6 bitwise
    do_op(11, 0, 1, 'hFF00, 'h8F0F, "R6 and");
    do_op(10, 0, 1, 'hFFFF, 'hFFFF, "R6 xor zero");
    ld('h0107);
    do_op(8, 0, 1, 'h00FF, 'h1234, "R6 bic flags kept");
    do_op(9, 0, 1, 'h0F00, 'h0000, "R6 bis flags kept");
    // R7 flag-neutral moves
    ld('h0105);
    do_op(0, 0, 1, 'h0000, 'h5555, "R7 move");
    do_op(14, 0, 1, 0, 'hA1B2, "R7 swap bytes");
    // R8 byte rules
    ld('h0000);
    do_op(1, 1, 1, 'h02, 'hAB5F, "R8 byte to register");
    do_op(1, 1, 0, 'h02, 'hAB5F, "R8 byte to memory");
    do_op(1, 1, 1, 'h01, 'h007F, "R8 byte overflow");
    do_op(0, 1, 1, 'hCDEF, 'h1234, "R8 byte move");
    // R9 rotates
    do_op(13, 0, 1, 0, 'h8001, "R9 arithmetic shift");
    do_op(12, 0, 1, 0, 'h0002, "R9 rotate through carry");
    ld('h0001);
    do_op(12, 1, 1, 0, 'h0F04, "R9 byte rotate through carry");
    do_op(13, 1, 0, 0, 'hAA81, "R9 byte arithmetic shift memory");
    // R10 word-only operations
    do_op(15, 0, 1, 0, 'h1280, "R10 sign extend negative");
    do_op(15, 1, 1, 0, 'h347F, "R10 sign extend byte flag ignored");
    do_op(14, 1, 1, 0, 'h1234, "R10 swap byte flag ignored");
    // R11 control bits preserved
    ld('hFEF8);
    do_op(1, 0, 1, 'h0001, 'hFFFF, "R11 control bits after add");
    do_op(13, 0, 1, 0, 'h0003, "R11 control bits after shift");
    do_op(6, 0, 1, 'h0001, 'h0009, "R11 control bits after decimal");
    // R12 idle and load priority
    step(1'b0, 1, 1'b0, 1'b1, 'h1111, 'h2222, 1'b0, 0, "R12 idle hold");
    step(1'b0, 4, 1'b1, 1'b0, 'h3333, 'h4444, 1'b0, 0, "R12 idle hold again");
    step(1'b1, 1, 1'b0, 1'b1, 1, 'hFFFF, 1'b1, 'h0003, "R12 load wins over flags");
    finish_run();
  end

endmodule